// File: doc/BRIEF.md
# MSK baseband phase modulator

This block turns a serial bit stream into digital baseband I and Q samples for continuous-phase minimum shift keying. One bit is carried per symbol, so the bit rate and the symbol rate are equal. Each accepted bit is read as +1 (bit 1) or -1 (bit 0). It steers a phase accumulator, which ramps linearly by exactly a quarter turn over the symbol in the bit's direction. This is a modulation index of one half, and the phase never jumps at a symbol boundary.

The accumulator is an unsigned `PHASE_W`-bit word that wraps modulo one full turn, so a quarter turn is 2^(PHASE_W-2) counts. A symbol spans `SPS` sample-enable pulses, and each enable moves the phase by 2^(PHASE_W-2)/`SPS` counts. `SPS` must divide that value exactly and be at least 2. The phase feeds a cosine/sine lookup built on a quarter-wave table. I is the cosine of the phase and Q is its sine, both as signed `AMP_W`-bit words with peak magnitude A = 2^(AMP_W-1)-1. The upstream source holds a bit with its valid flag. It sees the symbol strobe in the cycle its bit is taken.

Top module: `msk_modulator`

## Requirements
- R1: After synchronous reset the phase is zero, the sample index is zero, I equals A (127 at the defaults) and Q equals 0.
- R2: `sym_strobe` is high exactly in cycles where `sample_en` is high and the sample index within the symbol is 0. It therefore pulses once every `SPS` enables, and the first enable after reset carries one.
- R3: A strobe cycle with `bit_valid`=1 and `bit_in`=1 makes the phase rise by INC = 2^(PHASE_W-2)/SPS counts on that enable and on each of the next SPS-1 enables, a total of +90 degrees.
- R4: A strobe cycle with `bit_valid`=1 and `bit_in`=0 makes the phase fall by INC on each of the symbol's SPS enables, a total of -90 degrees.
- R5: A strobe cycle with `bit_valid`=0 holds the phase for the whole symbol, so I and Q stay constant.
- R6: `bit_valid` and `bit_in` in cycles without a strobe have no effect on the phase or on the outputs.
- R7: While `sample_en` is low, the phase, the sample index, I and Q do not change.
- R8: I = round(A*cos(theta)) and Q = round(A*sin(theta)), with theta = 2*pi*phase/2^PHASE_W and rounding half away from zero. Neither output ever reaches -2^(AMP_W-1).
- R9: Outputs lag the phase by two samples: after enable k, I and Q reflect the phase value held before enable k-1.
- R10: The phase wraps modulo 2^PHASE_W, so repeated rises or falls pass through a full turn with no discontinuity in I and Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Advance one output sample in this cycle |
| bit_valid | input | 1 | A bit is offered on `bit_in` |
| bit_in | input | 1 | Data bit: 1 turns the phase up, 0 turns it down |
| i_out | output | AMP_W | Signed in-phase sample (cosine) |
| q_out | output | AMP_W | Signed quadrature sample (sine) |
| sym_strobe | output | 1 | Offered bit is taken in this cycle (symbol start) |

## Verification
Two events can fall in one cycle: the symbol-boundary decision that picks the next direction, and the last ramp step of the previous symbol reaching a wrap of the phase word through zero. The bench provokes this by running long same-direction streaks in both directions. Each streak ends on an exact multiple of a quarter turn, so the boundary always lands on a wrap or an axis crossing. Hold symbols, off-boundary bit garbage and enable gaps are mixed in. Every cycle is judged against an arithmetic model of phase, two-sample latency and rounded cosine and sine, and the strobe is judged in the same cycle.

// File: rtl/msk_pkg.sv
package msk_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    // Rounded magnitude of amp*sin(pi/2 * idx/quarter), half away from zero.
    function automatic int sine_mag(input int idx, input int quarter, input int amp);
        real th;
        th = 1.5707963267948966 * real'(idx) / real'(quarter);
        return $rtoi($floor(real'(amp) * $sin(th) + 0.5));
    endfunction

endpackage

// File: rtl/msk_symbol_timer.sv
module msk_symbol_timer
    import msk_pkg::*;
#(
    parameter int SPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic bit_valid,
    input  logic bit_in,
    output logic sym_strobe,
    output dir_e step_dir
);
    localparam int CNT_W = (SPS > 2) ? $clog2(SPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPS - 1);

    logic [CNT_W-1:0] idx_q;
    dir_e             held_dir_q;
    dir_e             new_dir;

    always_comb begin
        if (!bit_valid)  new_dir = DIR_HOLD;
        else if (bit_in) new_dir = DIR_UP;
        else             new_dir = DIR_DOWN;
    end

    assign sym_strobe = sample_en && (idx_q == '0);
    assign step_dir   = (idx_q == '0) ? new_dir : held_dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            held_dir_q <= DIR_HOLD;
        end else if (sample_en) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            if (idx_q == '0) held_dir_q <= new_dir;
        end
    end

    // R2
    strobe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        sym_strobe |-> sample_en);
    // R2
    strobe_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        sym_strobe |=> !sym_strobe);
    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(idx_q));

endmodule

// File: rtl/msk_phase_acc.sv
module msk_phase_acc
    import msk_pkg::*;
#(
    parameter int PHASE_W = 10,
    parameter int SPS     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  dir_e               step_dir,
    output logic [PHASE_W-1:0] phase
);
    localparam int QUARTER = 1 << (PHASE_W - 2);
    localparam logic [PHASE_W-1:0] INC = PHASE_W'(QUARTER / SPS);

    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (sample_en) begin
            unique case (step_dir)
                DIR_UP:   phase_q <= phase_q + INC;
                DIR_DOWN: phase_q <= phase_q - INC;
                default:  phase_q <= phase_q;
            endcase
        end
    end

    assign phase = phase_q;

    // R3 R10
    rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && step_dir == DIR_UP) |=> (phase_q - $past(phase_q)) == INC);
    // R4 R10
    fall_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && step_dir == DIR_DOWN) |=> ($past(phase_q) - phase_q) == INC);
    // R5
    hold_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && step_dir == DIR_HOLD) |=> $stable(phase_q));
    // R7
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(phase_q));

endmodule

// File: rtl/msk_sincos.sv
module msk_sincos #(
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_en,
    input  logic [PHASE_W-1:0]      phase,
    output logic signed [AMP_W-1:0] i_out,
    output logic signed [AMP_W-1:0] q_out
);
    localparam int QUARTER = 1 << (PHASE_W - 2);
    localparam int MAG_W   = AMP_W - 1;
    localparam int AMP     = (1 << MAG_W) - 1;
    localparam int IDX_W   = PHASE_W - 1;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } half_t;

    logic [MAG_W-1:0] rom [0:QUARTER];

    for (genvar g = 0; g <= QUARTER; g++) begin : g_rom
        assign rom[g] = MAG_W'(msk_pkg::sine_mag(g, QUARTER, AMP));
    end

    logic [1:0]       quad_s, quad_c;
    logic [IDX_W-1:0] fwd_idx, rev_idx;
    half_t            sin_d, cos_d, sin_q, cos_q;

    assign quad_s  = phase[PHASE_W-1 -: 2];
    assign quad_c  = quad_s + 2'd1;
    assign fwd_idx = {1'b0, phase[PHASE_W-3:0]};
    assign rev_idx = IDX_W'(QUARTER) - fwd_idx;

    always_comb begin
        sin_d.neg = quad_s[1];
        sin_d.mag = quad_s[0] ? rom[rev_idx] : rom[fwd_idx];
        cos_d.neg = quad_c[1];
        cos_d.mag = quad_c[0] ? rom[rev_idx] : rom[fwd_idx];
    end

    function automatic logic signed [AMP_W-1:0] apply_sign(input half_t h);
        logic signed [AMP_W-1:0] v;
        v = signed'({1'b0, h.mag});
        return h.neg ? -v : v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '{neg: 1'b0, mag: '0};
            cos_q <= '{neg: 1'b0, mag: MAG_W'(AMP)};
            i_out <= AMP_W'(AMP);
            q_out <= '0;
        end else if (sample_en) begin
            sin_q <= sin_d;
            cos_q <= cos_d;
            i_out <= apply_sign(cos_q);
            q_out <= apply_sign(sin_q);
        end
    end

    // R7
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(i_out) && $stable(q_out)));
    // R8
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        (i_out != {1'b1, {(AMP_W-1){1'b0}}}) && (q_out != {1'b1, {(AMP_W-1){1'b0}}}));

endmodule

// File: rtl/msk_modulator.sv
module msk_modulator
    import msk_pkg::*;
#(
    parameter int PHASE_W = 10,
    parameter int SPS     = 8,
    parameter int AMP_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_en,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    output logic signed [AMP_W-1:0] i_out,
    output logic signed [AMP_W-1:0] q_out,
    output logic                    sym_strobe
);
    // SPS must be at least 2 and divide 2^(PHASE_W-2) exactly.
    dir_e               step_dir;
    logic [PHASE_W-1:0] phase;

    msk_symbol_timer #(.SPS(SPS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .sym_strobe (sym_strobe),
        .step_dir   (step_dir)
    );

    msk_phase_acc #(.PHASE_W(PHASE_W), .SPS(SPS)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .step_dir  (step_dir),
        .phase     (phase)
    );

    msk_sincos #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .phase     (phase),
        .i_out     (i_out),
        .q_out     (q_out)
    );

    // R6: an offered bit away from the strobe leaves the direction untouched
    off_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !sym_strobe) |=> $stable(u_timer.held_dir_q));

endmodule

// File: tb/tb_msk_modulator.sv
module tb_msk_modulator;
    localparam int PHASE_W = 10;
    localparam int SPS     = 8;
    localparam int AMP_W   = 8;
    localparam int FULL    = 1 << PHASE_W;
    localparam int INC     = (FULL / 4) / SPS;
    localparam real AMPR   = 127.0;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic signed [AMP_W-1:0] i_out, q_out;
    logic sym_strobe;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    int ph_m = 0, s1_m = 0, out_m = 0, idx_m = 0, dir_m = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    msk_modulator #(.PHASE_W(PHASE_W), .SPS(SPS), .AMP_W(AMP_W)) dut (
        .clk(clk), .rst(rst), .sample_en(sample_en), .bit_valid(bit_valid),
        .bit_in(bit_in), .i_out(i_out), .q_out(q_out), .sym_strobe(sym_strobe)
    );

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi($floor(x + 0.5));
        return -$rtoi($floor(-x + 0.5));
    endfunction

    function automatic int exp_i(input int p);
        return rnd(AMPR * $cos(TWO_PI * real'(p) / real'(FULL)));
    endfunction

    function automatic int exp_q(input int p);
        return rnd(AMPR * $sin(TWO_PI * real'(p) / real'(FULL)));
    endfunction

    task automatic check(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // one cycle: drive at negedge, check strobe, clock, update model, check I/Q
    task automatic cycle(input logic en, input logic v, input logic b, input string tag);
        sample_en = en; bit_valid = v; bit_in = b;
        #1;
        check("R2", "sym_strobe", int'(sym_strobe), int'(en && idx_m == 0));
        @(posedge clk);
        if (en) begin
            out_m = s1_m;
            s1_m  = ph_m;
            if (idx_m == 0) dir_m = !v ? 0 : (b ? 1 : -1);
            ph_m  = (ph_m + dir_m * INC + FULL) % FULL;
            idx_m = (idx_m + 1) % SPS;
        end
        @(negedge clk);
        check(tag, "i_out (R8 R9)", int'(i_out), exp_i(out_m));
        check(tag, "q_out (R8 R9)", int'(q_out), exp_q(out_m));
    endtask

    // one symbol of SPS enables; the bit is presented at the boundary,
    // garbage (inverted bit) is offered on every other sample (R6)
    task automatic symbol(input logic v, input logic b, input logic garbage, input string tag);
        for (int s = 0; s < SPS; s++) begin
            if (s == 0) cycle(1'b1, v, b, tag);
            else        cycle(1'b1, garbage, ~b, tag);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "i_out at reset", int'(i_out), 127);
        check("R1", "q_out at reset", int'(q_out), 0);
        check("R1", "strobe without enable", int'(sym_strobe), 0);

        // R3 R10: five rising symbols pass through a full turn
        for (int k = 0; k < 5; k++) symbol(1'b1, 1'b1, 1'b0, "R3 R10");
        // R4 R10: nine falling symbols wrap back below zero
        for (int k = 0; k < 9; k++) symbol(1'b1, 1'b0, 1'b0, "R4 R10");
        // R5: no valid bit at boundary, phase holds
        symbol(1'b0, 1'b0, 1'b0, "R5");
        symbol(1'b0, 1'b1, 1'b0, "R5");
        // R6: valid garbage away from the boundary is ignored
        for (int k = 0; k < 4; k++) symbol(1'b1, k[0], 1'b1, "R6");
        // R7: enable gaps, including mid-symbol and at the boundary
        for (int k = 0; k < 3 * SPS; k++) begin
            cycle(1'b0, 1'b1, k[1], "R7");
            cycle(1'b1, 1'b1, 1'b1, "R7");
        end

        // long mixed stream: streaks, holds, gaps and garbage
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[2:0] != 3'd0, lfsr[5:3] != 3'd0, lfsr[8] | lfsr[9], "R8 R9 R10");
        end

        // reset mid-stream returns to the reset state (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ph_m = 0; s1_m = 0; out_m = 0; idx_m = 0; dir_m = 0;
        check("R1", "i_out after reset", int'(i_out), 127);
        check("R1", "q_out after reset", int'(q_out), 0);
        symbol(1'b1, 1'b1, 1'b0, "R1 R3");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule